// File: doc/BRIEF.md
# Trace Capture Controller with Timestamp

This block writes bus samples into a circular trace memory. Each clock cycle it assembles one wide record from the address bus, the data bus, the control lines, the port pins, eight user logic inputs and a timestamp. Cycles are kept only while a capture window is open. Two qualifier inputs control that window: a start qualifier opens it and a stop qualifier closes it. These qualifiers are normally driven by external event-match logic. An optional frame limit ends capture after a programmed number of stored records. After that, the controller stays frozen until it is armed again.

A prescaler derives a 100 ns tick from the system clock. A saturating timestamp counts these ticks from the moment of arming. The timestamp is written into each record in one of three forms:
- absolute: time since arming,
- relative: time since the first stored record, which is the trigger,
- delta: time since the previous stored record.

The host reads records through an independent synchronous read port while capture goes on. The host also sees the write pointer, a sticky full flag that can serve as a breakpoint source, a done flag and the window state. With `PTR_W = 15` the buffer holds 32768 records of 80 bits. The default is a smaller buffer.

The controller is a four-state machine:
- IDLE (after reset),
- ARMED (window closed),
- OPEN (window open, storing),
- DONE (frame limit reached).

Its transitions:
- `arm` from any state goes to ARMED and clears the pointer, count, flags and timestamp.
- ARMED goes to OPEN on start without stop.
- OPEN goes to ARMED on stop.
- ARMED or OPEN goes to DONE when a store reaches the limit.
- DONE leaves only on `arm`.

Top module: `trace_capture`

## Requirements
- R1: After reset the block is in IDLE: `wr_ptr` = 0, `trace_full` = 0, `capture_done` = 0, `window_open` = 0.
- R2: In IDLE, no record is stored, whatever the qualifier inputs do.
- R3: In ARMED, a cycle with `start_q` = 1 and `stop_q` = 0 stores that cycle's record and opens the window. Every following cycle without stop stores one record at `wr_ptr`, and `wr_ptr` then advances by one.
- R4: A cycle with `stop_q` = 1 stores nothing and leaves the window closed, even when `start_q` is 1 in the same cycle.
- R5: The record layout, from MSB to LSB, is {timestamp, user_in, port_pins, bus_ctrl, bus_data, bus_addr}, so `bus_addr` occupies the lowest bits.
- R6: When `frame_limit` is non-zero and the stored count reaches it, `capture_done` becomes 1 and nothing more is stored until `arm`. A limit of 0 means no limit.
- R7: `wr_ptr` wraps modulo 2^PTR_W. `trace_full` sets on the store to the last address and stays set until `arm`.
- R8: The timestamp advances by one every CLK_HZ/TICK_HZ clock cycles after arming and saturates at all ones.
- R9: `ts_mode` selects the stored time:
  - 0: absolute, time since arming.
  - 1: relative, time since the first record stored after arming, which therefore reads 0.
  - 2: delta, time since the previous stored record. The first record after arming is measured from arming.
  - 3: same as 0.
- R10: `rd_data` returns the record at `rd_addr` one clock later, and capture never stalls for a read.
- R11: `arm` in any state stores nothing in its own cycle, clears the pointer, count, full, done and the timestamp, and enters ARMED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arm / re-arm pulse |
| ts_mode | input | 2 | Timestamp form: 0 absolute, 1 relative, 2 delta, 3 absolute |
| frame_limit | input | CNT_W | Number of records before done; 0 for no limit |
| start_q | input | 1 | Window start qualifier |
| stop_q | input | 1 | Window stop qualifier |
| bus_addr | input | ADDR_W | Sampled address bus |
| bus_data | input | DATA_W | Sampled data bus |
| bus_ctrl | input | CTRL_W | Sampled control lines |
| port_pins | input | PIN_W | Sampled port pins |
| user_in | input | USER_W | User logic inputs |
| rd_addr | input | PTR_W | Host read address |
| rd_data | output | FRAME_W | Record read from the trace memory |
| wr_ptr | output | PTR_W | Next write address |
| trace_full | output | 1 | Sticky buffer-full flag |
| capture_done | output | 1 | Frame limit reached |
| window_open | output | 1 | Capture window is open |

## Verification
The pair of functions that can land on one clock edge is the frame limit and the pointer wrap. The bench arms with a limit equal to the buffer depth and holds the window open past it. The sixteenth store must therefore set `trace_full` and `capture_done` together and leave `wr_ptr` at 0. The next cycles must show no further pointer movement and no extra record at the read port. The colliding start and stop qualifiers are also driven in one cycle, and the bench judges that case by the unchanged pointer and the closed window.

// File: rtl/trace_pkg.sv
package trace_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_OPEN  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_e;

    typedef enum logic [1:0] {
        TS_ABS     = 2'd0,
        TS_REL     = 2'd1,
        TS_DELTA   = 2'd2,
        TS_ABS_ALT = 2'd3
    } ts_mode_e;

endpackage

// File: rtl/trace_tstamp.sv
module trace_tstamp
    import trace_pkg::*;
#(
    parameter int TS_W    = 32,
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_HZ = 10_000_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [1:0]      mode,
    output logic [TS_W-1:0] stamp
);
    localparam int DIV_RAW = CLK_HZ / TICK_HZ;
    localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
    localparam int PRE_W   = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PRE_W-1:0] pre;
    logic [TS_W-1:0]  ts;
    logic [TS_W-1:0]  trig_ts;
    logic [TS_W-1:0]  last_ts;
    logic             trig_seen;
    logic             tick;
    logic [TS_W-1:0]  rel_base;

    assign tick = (pre == PRE_W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre       <= '0;
            ts        <= '0;
            trig_ts   <= '0;
            last_ts   <= '0;
            trig_seen <= 1'b0;
        end else begin
            pre <= tick ? '0 : pre + 1'b1;
            if (tick && ts != '1) begin
                ts <= ts + 1'b1;
            end
            if (wr_en) begin
                last_ts <= ts;
                if (!trig_seen) begin
                    trig_seen <= 1'b1;
                    trig_ts   <= ts;
                end
            end
        end
    end

    assign rel_base = trig_seen ? trig_ts : ts;

    always_comb begin
        unique case (ts_mode_e'(mode))
            TS_REL:     stamp = ts - rel_base;
            TS_DELTA:   stamp = ts - last_ts;
            TS_ABS,
            TS_ABS_ALT: stamp = ts;
        endcase
    end

    AST_TS_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (ts == $past(ts)) || (ts == $past(ts) + 1'b1)); // R8
    AST_TS_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ts == '1) |=> ts == '1); // R8

endmodule

// File: rtl/trace_mem.sv
module trace_mem #(
    parameter int W  = 80,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
    import trace_pkg::*;
#(
    parameter int PTR_W = 10,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             start_q,
    input  logic             stop_q,
    input  logic [CNT_W-1:0] limit,
    output logic             wr_en,
    output logic [PTR_W-1:0] ptr,
    output logic             full,
    output logic             done,
    output logic             open
);
    cap_state_e       st, st_nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt + 1'b1;

    always_comb begin
        st_nxt = st;
        wr_en  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                st_nxt = ST_IDLE;
            end
            ST_ARMED: begin
                if (start_q && !stop_q) begin
                    wr_en  = 1'b1;
                    st_nxt = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (stop_q) begin
                    st_nxt = ST_ARMED;
                end else begin
                    wr_en = 1'b1;
                end
            end
            ST_DONE: begin
                st_nxt = ST_DONE;
            end
        endcase
        if (wr_en && limit != '0 && cnt_inc == limit) begin
            st_nxt = ST_DONE;
        end
        if (arm) begin
            st_nxt = ST_ARMED;
            wr_en  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            ptr  <= '0;
            cnt  <= '0;
            full <= 1'b0;
        end else begin
            st <= st_nxt;
            if (arm) begin
                ptr  <= '0;
                cnt  <= '0;
                full <= 1'b0;
            end else if (wr_en) begin
                ptr <= ptr + 1'b1;
                cnt <= cnt_inc;
                if (ptr == '1) begin
                    full <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        done = (st == ST_DONE);
        open = (st == ST_OPEN);
    end

    AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !arm) |=> ptr == $past(ptr)); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (ptr == $past(ptr)) || (ptr == $past(ptr) + 1'b1)); // R3
    AST_STOP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !arm) |=> ptr == $past(ptr)); // R4
    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !arm) |=> (st == ST_DONE) && (ptr == $past(ptr))); // R6
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !arm) |=> full); // R7
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (ptr == '0) && !full && (st == ST_ARMED)); // R11

endmodule

// File: rtl/trace_capture.sv
module trace_capture
    import trace_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int CTRL_W  = 4,
    parameter int PIN_W   = 12,
    parameter int USER_W  = 8,
    parameter int TS_W    = 32,
    parameter int PTR_W   = 10,
    parameter int CNT_W   = 16,
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_HZ = 10_000_000,
    localparam int FRAME_W = ADDR_W + DATA_W + CTRL_W + PIN_W + USER_W + TS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [1:0]         ts_mode,
    input  logic [CNT_W-1:0]   frame_limit,
    input  logic               start_q,
    input  logic               stop_q,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_data,
    input  logic [CTRL_W-1:0]  bus_ctrl,
    input  logic [PIN_W-1:0]   port_pins,
    input  logic [USER_W-1:0]  user_in,
    input  logic [PTR_W-1:0]   rd_addr,
    output logic [FRAME_W-1:0] rd_data,
    output logic [PTR_W-1:0]   wr_ptr,
    output logic               trace_full,
    output logic               capture_done,
    output logic               window_open
);
    logic               wr_en;
    logic [TS_W-1:0]    stamp;
    logic [FRAME_W-1:0] frame;

    trace_ctrl #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .start_q (start_q),
        .stop_q  (stop_q),
        .limit   (frame_limit),
        .wr_en   (wr_en),
        .ptr     (wr_ptr),
        .full    (trace_full),
        .done    (capture_done),
        .open    (window_open)
    );

    trace_tstamp #(.TS_W(TS_W), .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tstamp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (arm),
        .wr_en (wr_en),
        .mode  (ts_mode),
        .stamp (stamp)
    );

    assign frame = {stamp, user_in, port_pins, bus_ctrl, bus_data, bus_addr};

    trace_mem #(.W(FRAME_W), .AW(PTR_W)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (frame),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (wr_ptr == '0) && !trace_full && !capture_done && !window_open); // R1

endmodule

// File: tb/trace_capture_bench.sv
`timescale 1ns/1ps
module trace_capture_bench;
    localparam int ADDR_W = 16, DATA_W = 8, CTRL_W = 4, PIN_W = 12, USER_W = 8;
    localparam int TS_W = 8, PTR_W = 4, CNT_W = 16;
    localparam int CLK_HZ = 40_000_000, TICK_HZ = 10_000_000;
    localparam int DIV = CLK_HZ / TICK_HZ;
    localparam int FW = ADDR_W + DATA_W + CTRL_W + PIN_W + USER_W + TS_W;
    localparam int DEPTH = 1 << PTR_W;
    localparam int TS_MAX = (1 << TS_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic [1:0] ts_mode = 2'd0;
    logic [CNT_W-1:0] frame_limit = '0;
    logic start_q = 1'b0, stop_q = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_data = '0;
    logic [CTRL_W-1:0] bus_ctrl = '0;
    logic [PIN_W-1:0] port_pins = '0;
    logic [USER_W-1:0] user_in = '0;
    logic [PTR_W-1:0] rd_addr = '0;
    logic [FW-1:0] rd_data;
    logic [PTR_W-1:0] wr_ptr;
    logic trace_full, capture_done, window_open;

    always #4 clk = ~clk;

    trace_capture #(.TS_W(TS_W), .PTR_W(PTR_W), .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_trace_capture (
        .clk(clk), .rst_n(rst_n), .arm(arm), .ts_mode(ts_mode), .frame_limit(frame_limit),
        .start_q(start_q), .stop_q(stop_q), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_ctrl(bus_ctrl), .port_pins(port_pins), .user_in(user_in), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_ptr(wr_ptr), .trace_full(trace_full),
        .capture_done(capture_done), .window_open(window_open)
    );

    int n_chk = 0, n_fail = 0;
    logic [FW-1:0] exp_q[$];

    // bench model: 0 idle, 1 armed, 2 open, 3 done
    int m_st = 0, m_ptr = 0, m_cnt = 0, m_lim = 0, m_mode = 0;
    bit m_full = 0, m_trig = 0;
    int m_tts = 0, m_last = 0, el = 0, seq = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_ports(string tag);
        chk({tag, " wr_ptr"}, int'(wr_ptr), m_ptr);
        chk({tag, " full"}, int'(trace_full), int'(m_full));
        chk({tag, " done"}, int'(capture_done), int'(m_st == 3));
        chk({tag, " open"}, int'(window_open), int'(m_st == 2));
    endtask

    task automatic step(input bit a, input bit s, input bit p);
        int tsu, stv;
        bit wr;
        logic [ADDR_W-1:0] ad;
        logic [DATA_W-1:0] da;
        logic [CTRL_W-1:0] ct;
        logic [PIN_W-1:0] pn;
        logic [USER_W-1:0] us;
        @(negedge clk);
        seq++;
        ad = ADDR_W'(16'h1000 + seq * 3);
        da = DATA_W'(seq) ^ 8'h5A;
        ct = CTRL_W'(seq);
        pn = PIN_W'(12'hA00 + seq);
        us = ~USER_W'(seq);
        arm = a; start_q = s; stop_q = p;
        bus_addr = ad; bus_data = da; bus_ctrl = ct; port_pins = pn; user_in = us;
        if (a) begin
            m_st = 1; m_ptr = 0; m_cnt = 0; m_full = 0; m_trig = 0; m_last = 0; el = 0;
        end else begin
            tsu = el / DIV;
            if (tsu > TS_MAX) tsu = TS_MAX;
            wr = (m_st == 1 && s && !p) || (m_st == 2 && !p);
            if (m_st == 1 && s && !p) m_st = 2;
            else if (m_st == 2 && p) m_st = 1;
            if (wr) begin
                if (m_mode == 1) stv = tsu - (m_trig ? m_tts : tsu);
                else if (m_mode == 2) stv = tsu - m_last;
                else stv = tsu;
                if (!m_trig) begin m_trig = 1; m_tts = tsu; end
                m_last = tsu;
                exp_q.push_back({TS_W'(stv), us, pn, ct, da, ad});
                if (m_ptr == DEPTH - 1) m_full = 1;
                m_ptr = (m_ptr + 1) % DEPTH;
                m_cnt++;
                if (m_lim != 0 && m_cnt == m_lim) m_st = 3;
            end
            el++;
        end
        @(posedge clk);
        #2;
    endtask

    task automatic do_arm(int mode, int lim);
        m_mode = mode; m_lim = lim;
        @(negedge clk);
        ts_mode = 2'(mode); frame_limit = CNT_W'(lim);
        step(1, 0, 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    task automatic burst(int n);
        step(0, 1, 0);
        for (int i = 1; i < n; i++) step(0, 0, 0);
        step(0, 0, 1);
    endtask

    // monitor: reads back each new record through the host port and pops the scoreboard
    int  mon_last = 0;
    bit  mon_pend = 0;
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_pend) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R10 unexpected record: actual %h expected none", rd_data);
                end else begin
                    logic [FW-1:0] e;
                    e = exp_q.pop_front();
                    if (rd_data !== e) begin
                        n_fail++;
                        $display("FAIL R5 R9 R10 record: actual %h expected %h", rd_data, e);
                    end
                end
            end
            if (arm) begin
                mon_last = 0; mon_pend = 0;
            end else if (int'(wr_ptr) != mon_last) begin
                rd_addr = wr_ptr - 1'b1;
                mon_last = int'(wr_ptr);
                mon_pend = 1;
            end else begin
                mon_pend = 0;
            end
        end
    end

    initial begin
        #1_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk_ports("R1 reset");
        @(negedge clk); rst_n = 1'b1;
        // R2: qualifiers before arming are ignored
        step(0, 1, 0); step(0, 0, 0); step(0, 1, 1);
        chk_ports("R2 idle");
        // R3 R9 absolute, R4 stop
        do_arm(0, 0);
        chk_ports("R11 arm");
        idle(3);
        step(0, 1, 0); step(0, 0, 0);
        chk_ports("R3 open");
        step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
        step(0, 0, 1);
        chk_ports("R4 stop");
        idle(2);
        step(0, 1, 1);
        chk_ports("R4 start with stop");
        idle(2);
        // R9 relative
        do_arm(1, 0);
        idle(5); burst(3); idle(7); burst(2); idle(2);
        chk_ports("R9 relative");
        // R9 delta and R6 limit
        do_arm(2, 6);
        idle(2); burst(2); idle(9); step(0, 1, 0); idle(2); idle(3);
        chk_ports("R6 done");
        burst(3);
        chk_ports("R6 frozen");
        idle(2);
        // R9 mode 3 behaves as absolute
        do_arm(3, 0);
        idle(6); burst(2); idle(2);
        chk_ports("R9 mode3");
        // R7 wrap without limit
        do_arm(0, 0);
        step(0, 1, 0); idle(15);
        chk_ports("R7 first wrap");
        idle(4); step(0, 0, 1);
        chk_ports("R7 after wrap");
        idle(2);
        // limit coinciding with wrap (R6 R7)
        do_arm(2, DEPTH);
        step(0, 1, 0); idle(DEPTH - 1);
        chk_ports("R6 R7 limit at wrap");
        idle(3);
        chk_ports("R6 R7 hold");
        // R11 re-arm from done clears flags
        do_arm(0, 0);
        chk_ports("R11 rearm");
        // R8 saturation
        idle(1100);
        burst(2);
        idle(3);
        chk_ports("R8 saturate");
        chk("R10 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule